// File: doc/BRIEF.md
# Nonvolatile Memory Command Launch and Status Register

This block is the status register that software uses to start commands on a nonvolatile memory controller. Software first loads a command elsewhere. It then writes 1 to the `done` flag of this register. That write clears the flag and sends a single-cycle start pulse to the command engine. The `done` flag stays low until the engine reports completion, or until an illegal-sequence violation aborts the command. An interrupt follows the `done` flag whenever its enable is high.

Two sticky error flags record problems:
- `acc_err` records illegal command sequences, illegal commands and errors from the buffer initialisation at reset.
- `prot_err` records program or erase attempts on protected addresses.

Software clears each flag by writing 1 to its bit. While either flag is set, every launch attempt is refused. The register also shows a busy bit and a two-bit execution status that the engine reports. The command decoder, the protection checker and the memory array sit outside the block and appear only as input strobes.

Top module: `flash_cmd_stat`

## Requirements
- R1: Out of reset, `rd_data` reads 0x01: `done` (bit 0) is 1 and `acc_err` (bit 1), `prot_err` (bit 2), busy (bit 3) and the execution status (bits 5:4) are all 0.
- R2: A write with bit 0 = 1, made while `done`=1 and both error flags are 0, is accepted. In the cycle after the write, `done` reads 0 and `start_o` is high for exactly that one cycle.
- R3: An `eng_done` pulse sets `done` to 1 and ORs `eng_stat` into bits 5:4. If it arrives while `done` is already 1, it counts as a reset-time status report and only updates bits 5:4.
- R4: While `acc_err` is 1, a write with bit 0 = 1 leaves `done` at 1 and does not raise `start_o`.
- R5: While `prot_err` is 1, a write with bit 0 = 1 leaves `done` at 1 and does not raise `start_o`.
- R6: Writing 1 to bit 1 clears `acc_err`, and writing 1 to bit 2 clears `prot_err`. Writing 0 to either bit leaves that flag unchanged.
- R7: `seq_err_stb` or `init_err_stb` sets `acc_err`. If `seq_err_stb` arrives while a command is in progress, it also returns `done` to 1.
- R8: `prot_viol_stb` sets `prot_err`.
- R9: Bit 3 (busy) reads 1 while `done`=0 or `bg_busy`=1, and reads 0 otherwise.
- R10: If a launch write and a violation strobe arrive in the same cycle, the error flag sets, `start_o` stays low and `done` stays 1.
- R11: An accepted launch clears the execution status (bits 5:4).
- R12: `irq_o` equals `done` AND `irq_en`.
- R13: Bits 7:6 always read 0. A write with bit 0 = 1 while `done`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bits 2:0 carry the launch and clear requests |
| irq_en | input | 1 | Enables the completion interrupt |
| eng_done | input | 1 | Engine completion pulse |
| eng_stat | input | 2 | Execution error code, valid with `eng_done` |
| seq_err_stb | input | 1 | Illegal sequence or illegal command |
| init_err_stb | input | 1 | Reset-time buffer initialisation error |
| prot_viol_stb | input | 1 | Protected-address violation |
| bg_busy | input | 1 | Engine busy with background work |
| rd_data | output | 8 | Register read value |
| start_o | output | 1 | Single-cycle command start pulse |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench tries to launch while each error flag is set in turn. A design that ignored the interlock would drop `done` and pulse `start_o`. It also writes zeros to the error bits; a design that treated those writes as clears would lose the sticky flags. A launch collides with a protection strobe in the same cycle, where an order-swapped design would start the engine anyway. The bench also sends a sequence error in the middle of a command, which must return `done` to 1, and a status report while idle, which must not disturb `done`.

// File: rtl/flash_cmd_stat.sv
module flash_cmd_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       irq_en,
  input  logic       eng_done,
  input  logic [1:0] eng_stat,
  input  logic       seq_err_stb,
  input  logic       init_err_stb,
  input  logic       prot_viol_stb,
  input  logic       bg_busy,
  output logic [7:0] rd_data,
  output logic       start_o,
  output logic       irq_o
);
  localparam int B_DONE = 0;
  localparam int B_ACC  = 1;
  localparam int B_PROT = 2;

  logic       done_q, acc_q, prot_q;
  logic [1:0] xstat_q;
  logic       viol, launch;

  assign viol   = seq_err_stb | init_err_stb | prot_viol_stb;
  assign launch = wr_en & wr_data[B_DONE] & done_q & ~acc_q & ~prot_q & ~viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b1;
      acc_q   <= 1'b0;
      prot_q  <= 1'b0;
      xstat_q <= 2'b00;
      start_o <= 1'b0;
    end else begin
      start_o <= launch;

      if (launch)
        done_q <= 1'b0;
      else if (eng_done || seq_err_stb)
        done_q <= 1'b1;

      if (seq_err_stb || init_err_stb)
        acc_q <= 1'b1;
      else if (wr_en && wr_data[B_ACC])
        acc_q <= 1'b0;

      if (prot_viol_stb)
        prot_q <= 1'b1;
      else if (wr_en && wr_data[B_PROT])
        prot_q <= 1'b0;

      if (launch)
        xstat_q <= 2'b00;
      else if (eng_done)
        xstat_q <= xstat_q | eng_stat;
    end
  end

  assign rd_data = {2'b00, xstat_q, ~done_q | bg_busy, prot_q, acc_q, done_q};
  assign irq_o   = done_q & irq_en;
endmodule

// File: rtl/flash_cmd_stat_chk.sv
module flash_cmd_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       irq_en,
  input logic [7:0] rd_data,
  input logic       start_o,
  input logic       irq_o
);
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !rd_data[0]);
  assert_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(rd_data[0] && !rd_data[1] && !rd_data[2] && wr_en && wr_data[0]));
  assert_busy_when_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |-> rd_data[3]);
  assert_acc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && !(wr_en && wr_data[1])) |=> rd_data[1]);
  assert_prot_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2] && !(wr_en && wr_data[2])) |=> rd_data[2]);
  assert_irq_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (rd_data[0] && irq_en));
  assert_rsvd_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00);
endmodule

bind flash_cmd_stat flash_cmd_stat_chk chk_i (.*);

// File: tb/flash_cmd_stat_tb_top.sv
module flash_cmd_stat_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic irq_en = 1'b1;
  logic eng_done = 1'b0;
  logic [1:0] eng_stat = 2'b00;
  logic seq_err_stb = 1'b0, init_err_stb = 1'b0, prot_viol_stb = 1'b0, bg_busy = 1'b0;
  logic [7:0] rd_data;
  logic start_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  typedef struct {
    logic [7:0] rd;
    logic       st;
    logic       irq;
    string      req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  flash_cmd_stat dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .eng_done(eng_done), .eng_stat(eng_stat), .seq_err_stb(seq_err_stb),
    .init_err_stb(init_err_stb), .prot_viol_stb(prot_viol_stb), .bg_busy(bg_busy),
    .rd_data(rd_data), .start_o(start_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (rd_data !== e.rd || start_o !== e.st || irq_o !== e.irq) begin
        n_fail++;
        $display("FAIL %s: rd=%h st=%b irq=%b expected rd=%h st=%b irq=%b",
                 e.req, rd_data, start_o, irq_o, e.rd, e.st, e.irq);
      end
    end
  end

  task automatic cyc(input logic we, input logic [7:0] wd, input logic ed, input logic [1:0] es,
                     input logic seq, input logic ini, input logic prt, input logic bg,
                     input logic ien, input logic [7:0] erd, input logic est, input string req);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; eng_done = ed; eng_stat = es;
    seq_err_stb = seq; init_err_stb = ini; prot_viol_stb = prt; bg_busy = bg; irq_en = ien;
    e.rd = erd; e.st = est; e.irq = erd[0] & ien; e.req = req;
    q.push_back(e);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (rd_data !== 8'h01 || start_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: rd=%h st=%b expected rd=01 st=0", rd_data, start_o);
    end
    rst_n = 1'b1;
    cyc(0, 8'h00, 0, 2'b00, 0, 0, 0, 0, 1, 8'h01, 0, "R1 idle after reset");
    cyc(1, 8'h01, 0, 2'b00, 0, 0, 0, 0, 1, 8'h08, 1, "R2 launch");
    cyc(0, 8'h00, 0, 2'b00, 0, 0, 0, 0, 1, 8'h08, 0, "R2 single pulse");
    cyc(1, 8'h01, 0, 2'b00, 0, 0, 0, 0, 1, 8'h08, 0, "R13 launch while running");
    cyc(0, 8'h00, 1, 2'b10, 0, 0, 0, 0, 1, 8'h21, 0, "R3 completion with status");
    cyc(1, 8'h01, 0, 2'b00, 0, 0, 0, 0, 1, 8'h08, 1, "R11 launch clears status");
    cyc(0, 8'h00, 1, 2'b00, 0, 0, 0, 0, 1, 8'h01, 0, "R3 clean completion");
    cyc(0, 8'h00, 0, 2'b00, 1, 0, 0, 0, 1, 8'h03, 0, "R7 sequence error");
    cyc(1, 8'h01, 0, 2'b00, 0, 0, 0, 0, 1, 8'h03, 0, "R4 blocked by access error");
    cyc(1, 8'h00, 0, 2'b00, 0, 0, 0, 0, 1, 8'h03, 0, "R6 write zero keeps access error");
    cyc(1, 8'h02, 0, 2'b00, 0, 0, 0, 0, 1, 8'h01, 0, "R6 clear access error");
    cyc(0, 8'h00, 0, 2'b00, 0, 0, 1, 0, 1, 8'h05, 0, "R8 protection violation");
    cyc(1, 8'h01, 0, 2'b00, 0, 0, 0, 0, 1, 8'h05, 0, "R5 blocked by protection error");
    cyc(1, 8'h04, 0, 2'b00, 0, 0, 0, 0, 1, 8'h01, 0, "R6 clear protection error");
    cyc(1, 8'h01, 0, 2'b00, 0, 0, 1, 0, 1, 8'h05, 0, "R10 violation beats launch");
    cyc(1, 8'h04, 0, 2'b00, 0, 0, 0, 0, 1, 8'h01, 0, "R6 clear protection error again");
    cyc(0, 8'h00, 0, 2'b00, 0, 1, 0, 0, 1, 8'h03, 0, "R7 init error");
    cyc(1, 8'h02, 0, 2'b00, 0, 0, 0, 0, 1, 8'h01, 0, "R6 clear after init error");
    cyc(0, 8'h00, 0, 2'b00, 0, 0, 0, 1, 1, 8'h09, 0, "R9 background busy");
    cyc(0, 8'h00, 0, 2'b00, 0, 0, 0, 0, 0, 8'h01, 0, "R12 irq disabled");
    cyc(1, 8'h01, 0, 2'b00, 0, 0, 0, 0, 1, 8'h08, 1, "R12 no irq while running");
    cyc(0, 8'h00, 0, 2'b00, 1, 0, 0, 0, 1, 8'h03, 0, "R7 abort returns done");
    cyc(1, 8'hC2, 0, 2'b00, 0, 0, 0, 0, 1, 8'h01, 0, "R13 reserved bits read zero");
    cyc(0, 8'h00, 1, 2'b01, 0, 0, 0, 0, 1, 8'h11, 0, "R3 idle status report");
    cyc(0, 8'h00, 0, 2'b00, 0, 0, 0, 0, 1, 8'h11, 0, "R3 status held");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule